// File: doc/BRIEF.md
# Latched-Address RAM Cycle Sequencer

This block sits between a simple host request port and a static RAM that captures its address on the falling edge of an active-low enable strobe. It shares one data bus for reads and writes. Each host request becomes a complete strobe sequence on the RAM side: enable, two active-low selects, active-low write enable, address, and outgoing data with its own drive enable. Every timing minimum is a parameter counted in system clocks. These minimums are address setup, enable low width, enable high width, access time, output disable time, write pulse width and full cycle time. Each one is checked against its own down-counter.

The order of the strobes is chosen so that the RAM and the controller never drive the shared bus at the same time. For a write, the write strobe goes low while both selects are still high, so the RAM output buffers can never turn on. For a run of writes, the write strobe stays low between cycles. A read ends in a fixed order. First the enable rises, which latches the RAM output. Then the selects rise. The request completes only after the disable time has passed, so a following write cannot collide with bus data that is still draining.

The host issues a one-cycle `req` while the block is idle and waits for the one-cycle `done` pulse.

Top module: `ramseq_ctrl`

## Requirements
- R1: While `rst_n` is low, `ram_ce_n`, `ram_sel1_n`, `ram_sel2_n` and `ram_we_n` are all 1, and `ram_dq_oe`, `done` and `rdata` are all 0.
- R2: A request is taken only when the block is idle. A `req` pulse during a cycle in progress produces no extra RAM cycle, no extra `done` and no write. `addr` and `wdata` changes at that time do not reach the RAM pins.
- R3: `ram_a` holds the accepted address for at least T_ASU clocks before `ram_ce_n` falls. It does not change while `ram_ce_n` is low.
- R4: In every cycle, `ram_ce_n`, `ram_sel1_n` and `ram_sel2_n` fall on the same clock edge. In a write, `ram_we_n` was already low in the clock before that edge.
- R5: A write ends with `ram_ce_n` and both selects rising together while `ram_we_n` is still low, and `ram_dq_oe` drops on that same edge.
- R6: `ram_dq_oe` is 1 only while `ram_we_n` is 0. The controller never drives the bus while the RAM drives it: with both selects low and `ram_we_n` high, or during the disable time that follows.
- R7: A read keeps `ram_we_n` high. `rdata` captures `ram_dq_i` at the edge max(T_ACC, T_EL, T_AH) clocks after `ram_ce_n` falls. `rdata` then keeps that value until the next read captures, so writes leave it unchanged.
- R8: A read releases the bus in this order: `ram_ce_n` rises while the selects stay low for one clock, then the selects rise, then `done` follows exactly T_DIS clocks after the selects rise.
- R9: `ram_ce_n` stays high for at least T_EH clocks between cycles. It stays low for at least T_EL clocks in every cycle.
- R10: Two consecutive falling edges of `ram_ce_n` are at least T_CYC clocks apart.
- R11: `done` is a one-clock pulse, given exactly once for each accepted request.
- R12: `ram_we_n` stays low between consecutive writes. It rises only when a read is accepted, while `ram_ce_n` and both selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-clock request pulse, taken only when idle |
| we | input | 1 | 1 = write request, 0 = read request |
| addr | input | AW | Request address |
| wdata | input | DW | Write data |
| rdata | output | DW | Last data read from the RAM |
| done | output | 1 | One-clock completion pulse |
| ram_ce_n | output | 1 | RAM enable, active low; its falling edge latches the address |
| ram_sel1_n | output | 1 | RAM select one, active low |
| ram_sel2_n | output | 1 | RAM select two, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_a | output | AW | RAM address |
| ram_dq_o | output | DW | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_o` |
| ram_dq_i | input | DW | Data returned from the RAM bus |

## Verification
The hardest case to reach from the ports is one where the timing minimums bind against each other, rather than the phase counters alone setting the pace. This happens with back-to-back writes, where the enable-high minimum, not address setup, sets when the next enable may fall. The bench issues long runs of consecutive writes so that this bound is hit repeatedly. A bench RAM model returns wrong data until the access count has elapsed and keeps driving the bus through its disable tail, so an early capture or an early bus turnaround shows up at the ports. Stray requests are injected in the middle of a cycle with a different address and data, and that address is read back later to show that nothing was written.

// File: rtl/ramseq_pkg.sv
package ramseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_SETUP    = 3'd1,
    PH_RD_ACC   = 3'd2,
    PH_RD_LATCH = 3'd3,
    PH_RD_REL   = 3'd4,
    PH_WR_PULSE = 3'd5,
    PH_FIN      = 3'd6
  } phase_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Enable strobe is low only in the two phases that hold the RAM cycle open
  function automatic logic ce_low(input phase_e p);
    return (p == PH_RD_ACC) || (p == PH_WR_PULSE);
  endfunction

  // Selects stay low through the latch phase of a read
  function automatic logic sel_low(input phase_e p);
    return (p == PH_RD_ACC) || (p == PH_RD_LATCH) || (p == PH_WR_PULSE);
  endfunction

endpackage

// File: rtl/ramseq_timer.sv
module ramseq_timer #(
  parameter int unsigned TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? val : (cnt_q - TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ramseq_fsm.sv
module ramseq_fsm
  import ramseq_pkg::*;
#(
  parameter int unsigned TW     = 5,
  parameter int unsigned T_ASU  = 4,
  parameter int unsigned RD_LOW = 12,
  parameter int unsigned WR_LOW = 8,
  parameter int unsigned T_DIS  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic          ph_exp,
  input  logic          eh_exp,
  input  logic          cyc_exp,
  output phase_e        phase_q,
  output logic          ph_load,
  output logic [TW-1:0] ph_val,
  output logic          eh_load,
  output logic          cyc_load,
  output logic          accept,
  output logic          capture,
  output logic          op_wr,
  output logic          we_n
);

  phase_e phase_d;
  logic   op_wr_q;
  logic   we_n_q;
  logic   we_n_d;
  logic   fall_ok;

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    accept  = 1'b0;
    capture = 1'b0;
    fall_ok = ph_exp && eh_exp && cyc_exp;
    unique case (phase_q)
      PH_IDLE: begin
        if (req) begin
          accept  = 1'b1;
          phase_d = PH_SETUP;
        end
      end
      PH_SETUP: begin
        if (fall_ok) begin
          phase_d = op_wr_q ? PH_WR_PULSE : PH_RD_ACC;
        end
      end
      PH_RD_ACC: begin
        if (ph_exp) begin
          capture = 1'b1;
          phase_d = PH_RD_LATCH;
        end
      end
      PH_RD_LATCH: phase_d = PH_RD_REL;
      PH_RD_REL: begin
        if (ph_exp) begin
          phase_d = PH_FIN;
        end
      end
      PH_WR_PULSE: begin
        if (ph_exp) begin
          phase_d = PH_FIN;
        end
      end
      PH_FIN:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  // Timer loads follow the phase and enable-strobe transitions
  always_comb begin
    ph_load  = (phase_d != phase_q);
    cyc_load = ce_low(phase_d) && !ce_low(phase_q);
    eh_load  = ce_low(phase_q) && !ce_low(phase_d);
    unique case (phase_d)
      PH_SETUP:    ph_val = TW'(T_ASU - 1);
      PH_RD_ACC:   ph_val = TW'(RD_LOW - 1);
      PH_RD_REL:   ph_val = TW'(T_DIS - 1);
      PH_WR_PULSE: ph_val = TW'(WR_LOW - 1);
      default:     ph_val = '0;
    endcase
  end

  // Write strobe changes only at acceptance, so it persists across writes
  always_comb begin
    we_n_d = accept ? !we : we_n_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wr_q <= 1'b0;
      we_n_q  <= 1'b1;
    end else if (accept) begin
      op_wr_q <= we;
      we_n_q  <= we_n_d;
    end
  end

  assign op_wr = op_wr_q;
  assign we_n  = we_n_q;

  // R9, R10: the enable may only fall once the high-width and cycle counters have run out
  assert_fall_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_load |-> (eh_exp && cyc_exp));

  // R2: a request outside idle starts nothing
  assert_idle_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> (phase_q != PH_SETUP) || $stable(phase_q));

endmodule

// File: rtl/ramseq_dpath.sv
module ramseq_dpath #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] rdata_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= dq_i;
    end
  end

  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;

  // R7: read data moves only on a capture
  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rdata_o));

endmodule

// File: rtl/ramseq_ctrl.sv
module ramseq_ctrl
  import ramseq_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 4,
  parameter int unsigned T_ASU = 4,
  parameter int unsigned T_AH  = 2,
  parameter int unsigned T_ACC = 12,
  parameter int unsigned T_DIS = 6,
  parameter int unsigned T_EH  = 10,
  parameter int unsigned T_EL  = 8,
  parameter int unsigned T_WP  = 6,
  parameter int unsigned T_CYC = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          ram_ce_n,
  output logic          ram_sel1_n,
  output logic          ram_sel2_n,
  output logic          ram_we_n,
  output logic [AW-1:0] ram_a,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_i
);

  localparam int unsigned LOW_MIN = umax(T_EL, T_AH);
  localparam int unsigned RD_LOW  = umax(T_ACC, LOW_MIN);
  localparam int unsigned WR_LOW  = umax(T_WP, LOW_MIN);
  localparam int unsigned TMAX    = umax(umax(umax(RD_LOW, WR_LOW), umax(T_ASU, T_DIS)),
                                         umax(T_EH, T_CYC));
  localparam int unsigned TW      = $clog2(TMAX + 1);
  localparam int unsigned NTMR    = 3;

  phase_e        phase_q;
  logic          ph_load;
  logic [TW-1:0] ph_val;
  logic          eh_load;
  logic          cyc_load;
  logic          accept;
  logic          capture;
  logic          op_wr;
  logic          we_n;
  logic [NTMR-1:0]         tmr_load;
  logic [NTMR-1:0][TW-1:0] tmr_val;
  logic [NTMR-1:0]         tmr_exp;

  ramseq_fsm #(
    .TW     (TW),
    .T_ASU  (T_ASU),
    .RD_LOW (RD_LOW),
    .WR_LOW (WR_LOW),
    .T_DIS  (T_DIS)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .we       (we),
    .ph_exp   (tmr_exp[0]),
    .eh_exp   (tmr_exp[1]),
    .cyc_exp  (tmr_exp[2]),
    .phase_q  (phase_q),
    .ph_load  (ph_load),
    .ph_val   (ph_val),
    .eh_load  (eh_load),
    .cyc_load (cyc_load),
    .accept   (accept),
    .capture  (capture),
    .op_wr    (op_wr),
    .we_n     (we_n)
  );

  // Timer 0: phase length, timer 1: enable high width, timer 2: fall-to-fall cycle
  assign tmr_load = {cyc_load, eh_load, ph_load};
  assign tmr_val  = {TW'(T_CYC - 1), TW'(T_EH - 1), ph_val};

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    ramseq_timer #(.TW(TW)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load[g]),
      .val     (tmr_val[g]),
      .expired (tmr_exp[g])
    );
  end

  ramseq_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .capture (capture),
    .addr_i  (addr),
    .wdata_i (wdata),
    .dq_i    (ram_dq_i),
    .addr_o  (ram_a),
    .dq_o    (ram_dq_o),
    .rdata_o (rdata)
  );

  assign ram_ce_n   = !ce_low(phase_q);
  assign ram_sel1_n = !sel_low(phase_q);
  assign ram_sel2_n = !sel_low(phase_q);
  assign ram_we_n   = we_n;
  assign ram_dq_oe  = op_wr && ((phase_q == PH_SETUP) || (phase_q == PH_WR_PULSE));
  assign done       = (phase_q == PH_FIN);

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce_n && !$past(ram_ce_n)) |-> $stable(ram_a));

  assert_we_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ram_sel1_n) && !ram_we_n) |-> !$past(ram_we_n));

  assert_wr_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ram_ce_n) && !ram_we_n) |-> (ram_sel1_n && ram_sel2_n && !ram_dq_oe));

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> !ram_we_n);

  assert_ce_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ram_sel1_n) && ram_we_n) |-> $past(ram_ce_n));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_we_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (ram_ce_n && ram_sel1_n && ram_sel2_n));

endmodule

// File: tb/ramseq_ctrl_tb.sv
module ramseq_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 4;
  localparam int T_ASU = 4, T_AH = 2, T_ACC = 12, T_DIS = 6;
  localparam int T_EH = 10, T_EL = 8, T_WP = 6, T_CYC = 17;

  logic clk = 1'b0;
  logic rst_n;
  logic req, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic done, ram_ce_n, ram_sel1_n, ram_sel2_n, ram_we_n, ram_dq_oe;
  logic [AW-1:0] ram_a;
  logic [DW-1:0] ram_dq_o, ram_dq_i;

  always #(CLK_PERIOD/2) clk = ~clk;

  ramseq_ctrl #(
    .AW(AW), .DW(DW), .T_ASU(T_ASU), .T_AH(T_AH), .T_ACC(T_ACC), .T_DIS(T_DIS),
    .T_EH(T_EH), .T_EL(T_EL), .T_WP(T_WP), .T_CYC(T_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .ram_ce_n(ram_ce_n), .ram_sel1_n(ram_sel1_n),
    .ram_sel2_n(ram_sel2_n), .ram_we_n(ram_we_n), .ram_a(ram_a), .ram_dq_o(ram_dq_o),
    .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i)
  );

  // ---------------- RAM model ----------------
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [AW-1:0] lat_a;
  int acc_cnt, dis_cnt;
  logic ram_drv;

  always @(negedge ram_ce_n) lat_a = ram_a;

  always @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt <= 0;
      dis_cnt <= 0;
      for (int i = 0; i < (1<<AW); i++) mem[i] <= '0;
    end else begin
      acc_cnt <= ram_ce_n ? 0 : acc_cnt + 1;
      if (!ram_ce_n && !ram_sel1_n && !ram_sel2_n && !ram_we_n) mem[lat_a] <= ram_dq_o;
      if (!ram_sel1_n && !ram_sel2_n && ram_we_n) dis_cnt <= T_DIS - 1;
      else if (dis_cnt > 0) dis_cnt <= dis_cnt - 1;
    end
  end

  assign ram_drv  = (!ram_sel1_n && !ram_sel2_n && ram_we_n) || (dis_cnt > 0);
  assign ram_dq_i = !ram_drv ? '0 : ((acc_cnt >= T_ACC - 1) ? mem[lat_a] : ~mem[lat_a]);

  // ---------------- scoreboard ----------------
  typedef struct { bit rd; logic [DW-1:0] d; } exp_t;
  exp_t exp_q[$];
  logic [DW-1:0] ref_mem [0:(1<<AW)-1];
  int vectors = 0, fails = 0, ops = 0, falls = 0, dones = 0, we_rises = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, expv, $time);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic do_op(input bit w, input int a, input int d, input bit poke);
    exp_t e;
    e.rd = !w;
    e.d  = ref_mem[a];
    if (w) ref_mem[a] = DW'(d);
    exp_q.push_back(e);
    ops++;
    @(negedge clk);
    req = 1'b1; we = w; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      // R2: stray request mid-cycle with another address and data
      @(negedge clk); @(negedge clk);
      req = 1'b1; we = 1'b1; addr = AW'(a ^ 8'hFF); wdata = ~DW'(d);
      @(negedge clk);
      req = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  // ---------------- protocol monitor ----------------
  logic prev_ce, prev_sel, prev_we, prev_done, first_fall;
  logic [AW-1:0] prev_a;
  int a_cnt, eh_cnt, el_cnt, cyc_cnt, sh_cnt;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ce = 1; prev_sel = 1; prev_we = 1; prev_done = 0; prev_a = ram_a;
      a_cnt = 0; eh_cnt = 100; el_cnt = 0; cyc_cnt = 100; sh_cnt = 100; first_fall = 1;
    end else begin
      if (ram_a !== prev_a) a_cnt = 0; else a_cnt++;
      cyc_cnt++;
      if (prev_ce && !ram_ce_n) begin
        falls++;
        chk(a_cnt >= T_ASU, "R3 address setup", a_cnt, T_ASU);
        chk(eh_cnt >= T_EH, "R9 enable high width", eh_cnt, T_EH);
        if (!first_fall) chk(cyc_cnt >= T_CYC, "R10 cycle time", cyc_cnt, T_CYC);
        chk(!ram_sel1_n && !ram_sel2_n, "R4 selects fall with enable", {ram_sel1_n, ram_sel2_n}, 0);
        if (!ram_we_n) chk(!prev_we, "R4 write strobe before selects", prev_we, 0);
        cyc_cnt = 0; el_cnt = 1; first_fall = 0;
      end else if (!ram_ce_n) begin
        el_cnt++;
        chk(ram_a == prev_a, "R3 address hold", ram_a, prev_a);
      end
      if (!prev_ce && ram_ce_n) begin
        chk(el_cnt >= T_EL, "R9 enable low width", el_cnt, T_EL);
        if (!ram_we_n)
          chk(ram_sel1_n && ram_sel2_n && !ram_dq_oe, "R5 write termination",
              {ram_sel1_n, ram_sel2_n, ram_dq_oe}, 3'b110);
        else
          chk(!ram_sel1_n, "R8 selects held after enable rise", ram_sel1_n, 0);
        eh_cnt = 1;
      end else if (ram_ce_n) begin
        eh_cnt++;
      end
      if (!prev_sel && ram_sel1_n) sh_cnt = 1;
      else if (ram_sel1_n) sh_cnt++;
      chk(!(ram_dq_oe && ram_drv) && !(ram_dq_oe && ram_we_n), "R6 bus contention",
          {ram_dq_oe, ram_drv, ram_we_n}, 0);
      if (!prev_we && ram_we_n) begin
        we_rises++;
        chk(ram_ce_n && ram_sel1_n && ram_sel2_n, "R12 write strobe rise", ram_sel1_n, 1);
      end
      if (done) begin
        exp_t e;
        dones++;
        chk(!prev_done, "R11 done width", prev_done, 0);
        if (ram_we_n) chk(sh_cnt == T_DIS + 1, "R8 release time", sh_cnt - 1, T_DIS);
        if (exp_q.size() == 0) chk(0, "R11 unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          if (e.rd) chk(rdata == e.d, "R7 read data", rdata, e.d);
        end
      end
      prev_ce = ram_ce_n; prev_sel = ram_sel1_n; prev_we = ram_we_n;
      prev_done = done; prev_a = ram_a;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL R11 watchdog expired act=%0d exp=%0d", dones, ops);
    report();
  end

  // ---------------- stimulus ----------------
  initial begin
    int rises_before;
    for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
    rst_n = 0; req = 0; we = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk(ram_ce_n && ram_sel1_n && ram_sel2_n && ram_we_n, "R1 strobes in reset",
        {ram_ce_n, ram_sel1_n, ram_sel2_n, ram_we_n}, 4'hF);
    chk(!ram_dq_oe && !done && rdata == 0, "R1 outputs in reset", {ram_dq_oe, done, rdata}, 0);
    rst_n = 1;
    @(negedge clk);

    // R12: run of writes with the strobe held low, boundary addresses and data
    do_op(1, 8'h00, 4'hA, 0);
    rises_before = we_rises;
    do_op(1, 8'hFF, 4'h5, 0);
    do_op(1, 8'h3C, 4'hF, 0);
    do_op(1, 8'h81, 4'h6, 0);
    chk(we_rises == rises_before, "R12 strobe low across writes", we_rises, rises_before);

    do_op(0, 8'h00, 0, 0);
    do_op(0, 8'hFF, 0, 0);
    do_op(0, 8'h3C, 0, 0);
    do_op(0, 8'h81, 0, 0);

    // R7: a write leaves rdata alone
    do_op(1, 8'h10, 4'h3, 1);
    chk(rdata == 4'h6, "R7 rdata held across write", rdata, 6);

    // R2: stray requests mid-read, then read the poked addresses
    do_op(0, 8'h55, 0, 1);
    do_op(0, 8'hEF, 0, 0);
    do_op(0, 8'hAA, 0, 0);
    do_op(0, 8'h10, 0, 0);

    for (int i = 0; i < 16; i++) do_op(1, i * 17, i, 0);
    for (int i = 15; i >= 0; i--) do_op(0, i * 17, 0, (i % 5) == 0);

    repeat (4) @(negedge clk);
    chk(falls == ops, "R2 one RAM cycle per request", falls, ops);
    chk(dones == ops, "R11 one done per request", dones, ops);
    chk(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);
    report();
  end

endmodule